// File: doc/BRIEF.md
# Standby Wake-Up Stabilization Timer

This block controls software standby for a processor core. While the core runs, a sleep strobe sent when the standby-enable bit is set moves the block into standby. There it holds the system clock enable low. In standby the block watches an interrupt pin through a synchronizer. It leaves standby on an edge of that pin whose direction comes from a polarity bit.

After the wake edge the clock stays gated while a counter runs on the oscillator clock. This gives the oscillator time to settle. A 3-bit select code picks the length of the wait. Codes 0 to 5 give power-of-two counts that double at each step. Code 7 gives a short 16-cycle wait, meant for an external clock source. Code 6 is reserved: it runs the longest wait and raises a sticky error flag. When the count ends, the clock enable rises and a one-cycle wake-done pulse tells the core it may resume.

A sleep strobe with standby disabled does nothing here, because another path handles plain idle sleep. Configuration is written through a single write strobe that loads all three fields at once.

Top module: `pdc_standby_ctrl`

## Requirements
- R1: In the running state, a sleep strobe seen at a clock edge while the standby-enable bit is 1 drives `clk_en_o` low from that edge on. It stays low for as long as no wake edge arrives.
- R2: A sleep strobe while the standby-enable bit is 0 has no effect: `clk_en_o` stays 1.
- R3: The wake edge on `nmi_i` is falling when the polarity bit is 0 and rising when it is 1. An edge of the other direction leaves the block in standby.
- R4: Select codes 0 to 5 give a wait of N = 2^(BASE_LOG2+code) cycles (8192 to 262144 at the default BASE_LOG2 = 13). `clk_en_o` is first seen high after the (N+3)th rising clock edge counted from the wake-edge change of `nmi_i`. This comprises two synchronizer stages, one edge to start the count, and N counted cycles.
- R5: Select code 7 gives a wait of 2^SHORT_LOG2 cycles (16 by default), with the same latency rule as R4.
- R6: Select code 6 gives the same wait as code 5. Writing code 6 sets `sel_err_o`, and `sel_err_o` stays 1 until reset.
- R7: `wake_done_o` is a one-cycle pulse that is high in exactly the cycle in which `clk_en_o` rises.
- R8: Edges on `nmi_i` while running or counting have no wake effect. Sleep strobes while in standby or counting are ignored, so the wait length is unchanged.
- R9: The wait length is captured at the wake edge. A configuration write during the count does not change it.
- R10: After reset, `clk_en_o` is 1, `wake_done_o` is 0 and `sel_err_o` is 0. The configuration fields are all 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Loads all configuration fields |
| cfg_sel_i | input | 3 | Wait select code |
| cfg_sby_en_i | input | 1 | Standby-enable bit |
| cfg_pol_i | input | 1 | Wake edge polarity (0 falling, 1 rising) |
| sleep_i | input | 1 | Sleep request strobe from the core |
| nmi_i | input | 1 | Asynchronous interrupt pin |
| clk_en_o | output | 1 | System clock enable |
| wake_done_o | output | 1 | One-cycle pulse when the clock is released |
| sel_err_o | output | 1 | Sticky flag for a reserved select write |

## Verification
The embedded properties check several rules on every cycle:
- the one-cycle entry into standby, and the ignored strobe when standby is disabled;
- the coincidence of the wake-done pulse with the clock-enable rise, and the pulse's single-cycle width;
- that the counter stays below its captured limit;
- that the error flag is sticky;
- that standby holds while no wake edge arrives.

Some behaviour only the bench scenarios can show, by comparing each cycle against a behavioural model:
- the exact end-to-end latency for every select code, including the reserved and short codes;
- rejection of the wrong-direction edge;
- that glitches, sleep strobes and configuration writes made during the count leave its length unchanged.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SBY  = 2'd1,
    ST_WAIT = 2'd2
  } pdc_state_e;

  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_RSVD  = 3'b110;
  localparam logic [SEL_W-1:0] SEL_SHORT = 3'b111;
  localparam int unsigned LONG_STEPS = 5;  // codes 0..5 double the wait
endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs
  import pdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sby_en_i,
  input  logic             pol_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             sby_en_o,
  output logic             pol_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      sby_en_o <= 1'b0;
      pol_o    <= 1'b0;
      err_o    <= 1'b0;
    end else if (we_i) begin
      sel_o    <= sel_i;
      sby_en_o <= sby_en_i;
      pol_o    <= pol_i;
      if (sel_i == SEL_RSVD) err_o <= 1'b1;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o)
    else $error("sel_err cleared without reset");

  p_err_on_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_RSVD) |=> err_o)
    else $error("reserved write did not flag");
endmodule

// File: rtl/pdc_edge_sync.sv
module pdc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  localparam int unsigned LEN = STAGES + 1;  // extra stage holds previous value
  logic [LEN-1:0] chain_q;

  for (genvar g = 0; g < LEN; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  logic cur, prv;
  assign cur = chain_q[LEN-2];
  assign prv = chain_q[LEN-1];
  assign edge_o = pol_i ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/pdc_wait_timer.sv
module pdc_wait_timer
  import pdc_pkg::*;
#(
  parameter int unsigned BASE_LOG2  = 13,
  parameter int unsigned SHORT_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             term_o
);
  localparam int unsigned CNT_W = BASE_LOG2 + LONG_STEPS + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, lim_q, lim_sel;

  always_comb begin
    unique case (sel_i)
      SEL_RSVD:  lim_sel = ONE << (BASE_LOG2 + LONG_STEPS);
      SEL_SHORT: lim_sel = ONE << SHORT_LOG2;
      default:   lim_sel = ONE << (BASE_LOG2 + 32'(sel_i));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= lim_sel;  // captured once per wake
    end else if (run_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign term_o = run_i && (cnt_q == lim_q - ONE);

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_q))
    else $error("wait counter passed its limit");

  p_lim_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && $past(run_i)) |-> $stable(lim_q))
    else $error("wait limit changed mid-count");
endmodule

// File: rtl/pdc_standby_ctrl.sv
module pdc_standby_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 13,
  parameter int unsigned SHORT_LOG2  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic             cfg_sby_en_i,
  input  logic             cfg_pol_i,
  input  logic             sleep_i,
  input  logic             nmi_i,
  output logic             clk_en_o,
  output logic             wake_done_o,
  output logic             sel_err_o
);
  logic [SEL_W-1:0] sel_q;
  logic sby_en_q, pol_q, wake_edge, term, load;
  pdc_state_e state_q, state_d;

  pdc_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .sby_en_i (cfg_sby_en_i),
    .pol_i    (cfg_pol_i),
    .sel_o    (sel_q),
    .sby_en_o (sby_en_q),
    .pol_o    (pol_q),
    .err_o    (sel_err_o)
  );

  pdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .pin_i  (nmi_i),
    .pol_i  (pol_q),
    .edge_o (wake_edge)
  );

  pdc_wait_timer #(.BASE_LOG2(BASE_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_timer (
    .clk_i, .rst_ni,
    .load_i (load),
    .run_i  (state_q == ST_WAIT),
    .sel_i  (sel_q),
    .term_o (term)
  );

  assign load = (state_q == ST_SBY) && wake_edge;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (sleep_i && sby_en_q) state_d = ST_SBY;
      ST_SBY:  if (wake_edge) state_d = ST_WAIT;
      ST_WAIT: if (term) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      wake_done_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_done_o <= term;
    end
  end

  assign clk_en_o = (state_q == ST_RUN);

  p_sleep_enters_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && sleep_i && sby_en_q) |=> !clk_en_o)
    else $error("standby not entered");

  p_sleep_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !sby_en_q) |=> clk_en_o)
    else $error("clock gated with standby disabled");

  p_done_with_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> wake_done_o)
    else $error("clock released without wake_done");

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o)
    else $error("wake_done wider than one cycle");

  p_sby_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SBY && !wake_edge) |=> (state_q == ST_SBY))
    else $error("standby left without wake edge");
endmodule

// File: tb/pdc_standby_ctrl_test.sv
module pdc_standby_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_LOG2  = 5;
  localparam int SHORT_LOG2 = 4;
  localparam int WDOG_LIMIT = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_pol = 0, sleep = 0, nmi = 0;
  logic [2:0] cfg_sel = 0;
  logic clk_en, wake_done, sel_err;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_standby_ctrl #(.BASE_LOG2(BASE_LOG2), .SHORT_LOG2(SHORT_LOG2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_sby_en_i(cfg_en), .cfg_pol_i(cfg_pol),
    .sleep_i(sleep), .nmi_i(nmi),
    .clk_en_o(clk_en), .wake_done_o(wake_done), .sel_err_o(sel_err)
  );

  function automatic int nwait(input int code);
    if (code == 6) return 1 << (BASE_LOG2 + 5);
    if (code == 7) return 1 << SHORT_LOG2;
    return 1 << (BASE_LOG2 + code);
  endfunction

  // behavioural reference model
  int m_state, m_cnt, m_lim, m_sel;
  bit m_en, m_pol, m_err, m_done, h1, h2, h3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_lim = 0; m_sel = 0;
      m_en = 0; m_pol = 0; m_err = 0; m_done = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit edge_seen;
      edge_seen = m_pol ? (h2 && !h3) : (!h2 && h3);
      h3 = h2; h2 = h1; h1 = nmi;
      m_done = 0;
      if (m_state == 0) begin
        if (sleep && m_en) m_state = 1;
      end else if (m_state == 1) begin
        if (edge_seen) begin m_state = 2; m_cnt = 0; m_lim = nwait(m_sel); end
      end else begin
        if (m_cnt == m_lim - 1) begin m_state = 0; m_done = 1; end
        else m_cnt++;
      end
      if (cfg_we) begin
        m_sel = cfg_sel; m_en = cfg_en; m_pol = cfg_pol;
        if (cfg_sel == 3'd6) m_err = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle model comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 model clk_en", int'(clk_en), int'(m_state == 0));
      chk("R7 model wake_done", int'(wake_done), int'(m_done));
      chk("R6 model sel_err", int'(sel_err), int'(m_err));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic write_cfg(input int sel, input bit en, input bit pol);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_en = en; cfg_pol = pol;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep = 1;
    @(negedge clk); sleep = 0;
  endtask

  // full standby round trip; glitch adds edges, a sleep strobe and a write mid-count
  task automatic round_trip(input int sel, input bit pol, input bit glitch);
    int n, cnt;
    n = nwait(sel);
    write_cfg(sel, 1'b1, pol);
    nmi = pol;
    repeat (4) @(negedge clk);
    pulse_sleep();
    chk("R1 clk_en low after sleep", int'(clk_en), 0);
    nmi = !pol;  // wrong-direction edge
    repeat (6) @(negedge clk);
    chk("R3 wrong edge keeps standby", int'(clk_en), 0);
    nmi = pol;   // wake edge
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (glitch) begin
        if (cnt == 10) nmi = !pol;
        if (cnt == 11) sleep = 1;
        if (cnt == 12) begin nmi = pol; sleep = 0; end
        if (cnt == 13) begin cfg_we = 1; cfg_sel = 3'd7; cfg_en = 1; cfg_pol = pol; end
        if (cnt == 14) cfg_we = 0;
      end
    end while (!clk_en && cnt < 5000);
    if (sel == 7) chk("R5 short wait latency", cnt, n + 3);
    else if (sel == 6) chk("R6 reserved wait latency", cnt, n + 3);
    else if (glitch) chk("R8 R9 latency with mid-count activity", cnt, n + 3);
    else chk("R4 wait latency", cnt, n + 3);
    chk("R7 wake_done with clk_en rise", int'(wake_done), 1);
    @(negedge clk);
    chk("R7 wake_done single cycle", int'(wake_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset clk_en", int'(clk_en), 1);
    chk("R10 reset wake_done", int'(wake_done), 0);
    chk("R10 reset sel_err", int'(sel_err), 0);
    rst_n = 1;
    // R10: reset config has standby disabled, so sleep does nothing
    pulse_sleep();
    chk("R10 reset standby-enable is 0", int'(clk_en), 1);

    write_cfg(0, 1'b0, 1'b0);
    pulse_sleep();
    repeat (3) @(negedge clk);
    chk("R2 sleep ignored when disabled", int'(clk_en), 1);

    // R8: edges while running
    nmi = 1; repeat (4) @(negedge clk); nmi = 0; repeat (5) @(negedge clk);
    chk("R8 edge in run no effect", int'(clk_en), 1);
    chk("R8 edge in run no pulse", int'(wake_done), 0);

    for (int c = 0; c < 6; c++) round_trip(c, 1'b0, 1'b0);
    round_trip(7, 1'b0, 1'b0);
    round_trip(1, 1'b1, 1'b0);
    round_trip(2, 1'b0, 1'b1);
    round_trip(0, 1'b1, 1'b1);

    write_cfg(6, 1'b1, 1'b0);
    @(negedge clk);
    chk("R6 reserved write sets error", int'(sel_err), 1);
    round_trip(6, 1'b0, 1'b0);
    write_cfg(0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 error sticky", int'(sel_err), 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R10 error cleared by reset", int'(sel_err), 0);
    chk("R10 clk_en after reset", int'(clk_en), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule